// File: doc/BRIEF.md
# Recursive Carry-Lookahead Adder

This block adds two unsigned operands and a carry input in pure combinational logic. It uses carry lookahead instead of a ripple chain. The carry logic is a binary tree. Each leaf is a one-bit cell that produces a sum bit, a generate term and a propagate term; the cell has no carry output of its own. At each level above the leaves, a two-input lookahead generator combines the generate/propagate pairs of two equal halves. It hands the lower half's carry-out to the upper half as that half's carry input, and it passes a group generate and a group propagate up to the next level.

With the default width of eight bits, the tree has three levels: 2-bit, 4-bit and 8-bit. Every internal carry comes from the external carry input or from the first carry output of some generator. The second carry output of a generator drives nothing, except at the root, where it becomes the final carry out. The group generate and group propagate of the whole operand are also brought out, so that a wider lookahead structure can use the block as one group.

Top module: `claAdder`

## Requirements
- R1: For every combination of `a`, `b` and `cin`, the concatenation {`cout`, `s`} equals the unsigned value `a + b + cin`.
- R2: `blkP` is 1 exactly when every bit position propagates, that is when `a ^ b` is all ones; otherwise it is 0.
- R3: `blkG` is 1 exactly when `a + b`, taken with no carry input, overflows the operand width (sum of at least 2^DATA_W); it does not depend on `cin`.
- R4: `cout` always equals `blkG | (blkP & cin)`.
- R5: The carry into each bit position i (1 to DATA_W-1) equals `s[i] ^ a[i] ^ b[i]`. It is 1 exactly when the low i bits of `a` and `b`, added with `cin`, reach 2^i. Each such internal carry can be driven to 1 by a pure generate (bit i-1 of both operands set) and by a pure propagate run (low i bits of `a` all ones, `b` zero, `cin` = 1).
- R6: The block holds no state. A given input vector gives the same outputs whatever vectors were applied before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | DATA_W | First operand, unsigned |
| b | input | DATA_W | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| s | output | DATA_W | Sum bits |
| cout | output | 1 | Carry out of the top bit, from the root generator's second carry |
| blkG | output | 1 | Group generate of the whole operand |
| blkP | output | 1 | Group propagate of the whole operand |

## Verification
The bench sweeps all 2^17 combinations of the two operands and the carry input, and compares the sum, carry out, group generate and group propagate against integer arithmetic. It begins with the four extreme vectors: zero plus zero with each carry input, and all ones plus all ones with each carry input. A tree with a swapped generate/propagate term, or with the wrong carry fed to an upper half, would give wrong sums in exactly those long-propagate and all-generate cases. The bench then drives every internal carry to 1, once through a generate at the bit just below and once through a full propagate run from the carry input, so that a single broken generator carry shows up as a flipped sum bit at the position it feeds. It also repeats a vector after different histories, to catch a design that kept state by accident.

// File: rtl/claPkg.sv
package claPkg;
  // Generate/propagate pair carried up the lookahead tree
  typedef struct packed {
    logic gen;
    logic prop;
  } gpPair_t;
endpackage

// File: rtl/claBitCell.sv
module claBitCell
  import claPkg::*;
(
  input  logic    a,
  input  logic    b,
  input  logic    cin,
  output logic    s,
  output gpPair_t gp
);
  always_comb begin
    gp.gen  = a & b;
    gp.prop = a ^ b;
    s       = gp.prop ^ cin;
  end
endmodule

// File: rtl/claCarryGen2.sv
module claCarryGen2
  import claPkg::*;
(
  input  logic    cin,
  input  gpPair_t loPair,
  input  gpPair_t hiPair,
  output logic    cout0,
  output logic    cout1,
  output gpPair_t blkPair
);
  always_comb begin
    cout0        = loPair.gen | (loPair.prop & cin);
    cout1        = hiPair.gen | (hiPair.prop & loPair.gen)
                 | (hiPair.prop & loPair.prop & cin);
    blkPair.gen  = hiPair.gen | (hiPair.prop & loPair.gen);
    blkPair.prop = hiPair.prop & loPair.prop;
  end
endmodule

// File: rtl/claGroup.sv
module claGroup
  import claPkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output gpPair_t      grpPair,
  output logic         grpCout
);
  generate
    if (W == 1) begin : gLeaf
      claBitCell uCell (
        .a   (a[0]),
        .b   (b[0]),
        .cin (cin),
        .s   (s[0]),
        .gp  (grpPair)
      );
      // A leaf cell has no carry output
      assign grpCout = 1'b0;
    end else begin : gNode
      localparam int HALF = W / 2;
      gpPair_t loPair;
      gpPair_t hiPair;
      logic    midCarry;
      logic    unusedLoCarry;
      logic    unusedHiCarry;

      claGroup #(.W(HALF)) uLo (
        .a       (a[HALF-1:0]),
        .b       (b[HALF-1:0]),
        .cin     (cin),
        .s       (s[HALF-1:0]),
        .grpPair (loPair),
        .grpCout (unusedLoCarry)
      );

      claGroup #(.W(W-HALF)) uHi (
        .a       (a[W-1:HALF]),
        .b       (b[W-1:HALF]),
        .cin     (midCarry),
        .s       (s[W-1:HALF]),
        .grpPair (hiPair),
        .grpCout (unusedHiCarry)
      );

      claCarryGen2 uGen (
        .cin     (cin),
        .loPair  (loPair),
        .hiPair  (hiPair),
        .cout0   (midCarry),
        .cout1   (grpCout),
        .blkPair (grpPair)
      );
    end
  endgenerate
endmodule

// File: rtl/claAdder.sv
module claAdder
  import claPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] s,
  output logic              cout,
  output logic              blkG,
  output logic              blkP
);
  gpPair_t rootPair;

  claGroup #(.W(DATA_W)) uTree (
    .a       (a),
    .b       (b),
    .cin     (cin),
    .s       (s),
    .grpPair (rootPair),
    .grpCout (cout)
  );

  assign blkG = rootPair.gen;
  assign blkP = rootPair.prop;
endmodule

// File: rtl/claAdderChecker.sv
module claAdderChecker #(
  parameter int W = 8
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         cin,
  input logic [W-1:0] s,
  input logic         cout,
  input logic         blkG,
  input logic         blkP
);
  logic [W:0] wideSum;
  logic [W:0] noCinSum;
  logic [W-1:0] bitCarry;

  always_comb begin
    wideSum  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    noCinSum = {1'b0, a} + {1'b0, b};
    bitCarry = s ^ a ^ b;
    AST_SUM_EXACT: assert ({cout, s} == wideSum);            // R1
    AST_BLKP_ALL_PROP: assert (blkP == &(a ^ b));            // R2
    AST_BLKG_NO_CIN: assert (blkG == noCinSum[W]);           // R3
    AST_COUT_FROM_GROUP: assert (cout == (blkG | (blkP & cin))); // R4
    AST_BIT0_CARRY: assert (bitCarry[0] == cin);             // R5
  end

  generate
    for (genvar i = 1; i < W; i++) begin : gBit
      logic [i:0] lowSum;
      always_comb begin
        lowSum = {1'b0, a[i-1:0]} + {1'b0, b[i-1:0]} + {{i{1'b0}}, cin};
        AST_BIT_CARRY: assert (bitCarry[i] == lowSum[i]);    // R5
      end
    end
  endgenerate
endmodule

bind claAdder claAdderChecker #(.W(DATA_W)) uChk (.*);

// File: tb/sim_claAdder.sv
module sim_claAdder;
  localparam int W = 8;
  localparam int MAXV = 1 << W;

  logic clk = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic cin = 1'b0;
  logic [W-1:0] s;
  logic cout, blkG, blkP;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  claAdder #(.DATA_W(W)) u0 (
    .a(a), .b(b), .cin(cin), .s(s), .cout(cout), .blkG(blkG), .blkP(blkP)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual cycles=%0d expected below 190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s a=%0h b=%0h cin=%0d actual=%0h expected=%0h", req, a, b, cin, act, exp);
    end
  endtask

  // Drive after a rising edge, sample at the following falling edge
  task automatic apply(input int av, input int bv, input int cv);
    @(posedge clk);
    #1;
    a = av[W-1:0];
    b = bv[W-1:0];
    cin = cv[0];
    @(negedge clk);
  endtask

  task automatic fullCheck(input int av, input int bv, input int cv);
    int total, noCin, xr;
    apply(av, bv, cv);
    total = av + bv + cv;
    noCin = av + bv;
    xr    = (av ^ bv) & (MAXV - 1);
    chk("R1", {cout, s}, total);
    chk("R2", blkP, (xr == MAXV - 1) ? 1 : 0);
    chk("R3", blkG, (noCin >= MAXV) ? 1 : 0);
    chk("R4", cout, ((noCin >= MAXV) || ((xr == MAXV - 1) && cv == 1)) ? 1 : 0);
  endtask

  initial begin
    // Reset-free block: first sample with all inputs zero
    @(negedge clk);
    chk("R1", {cout, s}, 0);

    // Extreme vectors (R1..R4)
    fullCheck(0, 0, 0);
    fullCheck(0, 0, 1);
    fullCheck(MAXV - 1, MAXV - 1, 0);
    fullCheck(MAXV - 1, MAXV - 1, 1);
    fullCheck(MAXV - 1, 0, 1);

    // R5: every internal carry driven to 1 by generate and by propagate run
    for (int i = 1; i < W; i++) begin
      apply(1 << (i - 1), 1 << (i - 1), 0);
      chk("R5", (s[i] ^ a[i] ^ b[i]) ? 1 : 0, 1);
      apply((1 << i) - 1, 0, 1);
      chk("R5", (s[i] ^ a[i] ^ b[i]) ? 1 : 0, 1);
      apply((1 << i) - 2, 0, 1);
      chk("R5", (s[i] ^ a[i] ^ b[i]) ? 1 : 0, 0);
    end

    // R6: same vector after two different histories
    apply(MAXV - 1, MAXV - 1, 1);
    fullCheck(8'h5a, 8'h36, 0);
    chk("R6", {cout, s}, 8'h5a + 8'h36);
    apply(0, 0, 0);
    fullCheck(8'h5a, 8'h36, 0);
    chk("R6", {cout, s}, 8'h5a + 8'h36);

    // Exhaustive sweep (R1..R4)
    for (int c = 0; c < 2; c++)
      for (int x = 0; x < MAXV; x++)
        for (int y = 0; y < MAXV; y++)
          fullCheck(x, y, c);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule